// File: doc/BRIEF.md
# Boot ROM Overlay Chip-Select Controller

This block generates the active-low memory selects for an 8-bit processor with a 16-bit address bus. It lets a boot ROM start the machine and then get out of the way. After a system reset the controller is in boot mode. In that mode any memory cycle that is not a write selects the ROM, so both instruction fetches and data reads come from it. Every memory write goes to RAM, even at addresses the ROM answers on reads. This lets loader code build an image in RAM underneath the ROM.

The first memory read whose top address bit is set moves the controller into run mode. An opcode fetch counts as a read, so jumping to code at 8000h or above is enough. From then on RAM serves every read and write, and the ROM stays deselected until the next system reset. No software register is needed to switch the ROM off.

Beside the overlay flag the controller keeps two boot-status bits:
- **Warm-boot bit.** It is cleared by power-on and by a keyed write to an I/O port. It is set when run mode is first entered. Boot code can therefore tell a power-on start from a later reset.
- **Hard-reset request.** It is raised when two system resets arrive with no entry to run mode between them.

Top module: `boot_overlay_cs`

## Requirements
- R1: While `por_n` is low (asynchronous), `run_mode`, `warm_boot` and `hard_reset_req` are all 0, and the boot that follows counts as not yet having reached run mode.
- R2: In boot mode (`run_mode`=0), a memory cycle (`mreq_n`=0) with `wr_n`=1 drives `rom_cs_n`=0 and `ram_cs_n`=1, whatever the address.
- R3: Any memory cycle with `wr_n`=0 drives `ram_cs_n`=0 and `rom_cs_n`=1, at every address and in both modes.
- R4: A memory read (`mreq_n`=0, `rd_n`=0) with the top address bit at 1, seen at a clock edge while `rst_n`=1, sets `run_mode` from the following cycle. The selects during that read cycle still follow boot-mode decoding.
- R5: In run mode, `rom_cs_n` stays 1, and every memory cycle drives `ram_cs_n`=0.
- R6: `rom_cs_n` and `ram_cs_n` are never 0 at the same time.
- R7: With `mreq_n`=1 both selects are 1. I/O cycles and idle cycles never change `run_mode`.
- R8: A clock edge with `rst_n`=0 clears `run_mode`.
- R9: `warm_boot` becomes 1 at the edge where `run_mode` goes from 0 to 1. A system reset leaves it unchanged.
- R10: An I/O write clears `warm_boot` at the next edge. The write must have `iorq_n`=0, `wr_n`=0, an address that matches CLR_PORT on the bits set in CLR_MASK, and `io_data` equal to CLR_KEY. A wrong key, a wrong port, or an I/O read leaves `warm_boot` unchanged.
- R11: At the first clock edge of each system reset (`rst_n`=0 now, 1 at the previous edge), `hard_reset_req` loads 1 if run mode was not entered since the previous reset or power-on, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous system reset, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Address bus |
| io_data | input | DATA_W | Data bus, sampled on I/O writes |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| run_mode | output | 1 | Overlay flag: 1 when the ROM is switched out |
| warm_boot | output | 1 | 1 when run mode was reached since the last power-on or clear |
| hard_reset_req | output | 1 | 1 when the last reset followed a reset with no run-mode entry |

## Verification
The bench builds the block with its default parameters:
- a 16-bit address,
- an 8-bit data bus,
- clear port F0h, decoded on the low address byte only,
- key A5h.

Because the mask ignores the high address byte, random I/O writes with random high bytes still hit the clear port. Random writes also exercise the wrong-key and wrong-port cases. Rare system resets, some of them back to back before run mode is reached, drive the hard-reset request both ways. Occasional power-on pulses restart the status bits in the middle of the run.

// File: rtl/boot_overlay_cs.sv
module boot_overlay_cs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CLR_PORT = 'h00F0,
  parameter logic [ADDR_W-1:0] CLR_MASK = 'h00FF,
  parameter logic [DATA_W-1:0] CLR_KEY  = 'hA5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] io_data,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              run_mode,
  output logic              warm_boot,
  output logic              hard_reset_req
);

  logic ovl, warm, pend, hard, rst_q;

  wire mem     = ~mreq_n;
  wire hi_read = mem & ~rd_n & addr[ADDR_W-1];
  wire go_run  = rst_n & hi_read & ~ovl;
  wire entry   = ~rst_n & rst_q;
  wire port_ok = ((addr ^ CLR_PORT) & CLR_MASK) == '0;
  wire io_clr  = ~iorq_n & ~wr_n & port_ok & (io_data == CLR_KEY);

  assign rom_cs_n       = ~(mem & ~ovl & wr_n);
  assign ram_cs_n       = ~(mem & (ovl | ~wr_n));
  assign run_mode       = ovl;
  assign warm_boot      = warm;
  assign hard_reset_req = hard;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ovl   <= 1'b0;
      warm  <= 1'b0;
      pend  <= 1'b1;
      hard  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= rst_n;
      if (!rst_n)       ovl <= 1'b0;
      else if (hi_read) ovl <= 1'b1;
      if (io_clr)       warm <= 1'b0;
      else if (go_run)  warm <= 1'b1;
      if (entry) begin
        pend <= 1'b1;
        hard <= pend;
      end else if (go_run) begin
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/boot_overlay_cs_chk.sv
module boot_overlay_cs_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] io_data,
  input logic              rom_cs_n,
  input logic              ram_cs_n,
  input logic              run_mode,
  input logic              warm_boot,
  input logic              hard_reset_req
);

  assert_por_state_R1: assert property (@(posedge clk) !por_n |-> (!run_mode && !warm_boot && !hard_reset_req));

  assert_boot_read_rom_R2: assert property (@(posedge clk) disable iff (!por_n)
    (!mreq_n && wr_n && !run_mode) |-> (!rom_cs_n && ram_cs_n));

  assert_write_ram_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!mreq_n && !wr_n) |-> (!ram_cs_n && rom_cs_n));

  assert_high_read_exit_R4: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && !mreq_n && !rd_n && addr[ADDR_W-1]) |=> run_mode);

  assert_run_no_rom_R5: assert property (@(posedge clk) disable iff (!por_n)
    run_mode |-> (rom_cs_n && (mreq_n || !ram_cs_n)));

  assert_exclusive_sel_R6: assert property (@(posedge clk) disable iff (!por_n)
    !(!rom_cs_n && !ram_cs_n));

  assert_idle_no_sel_R7: assert property (@(posedge clk) disable iff (!por_n)
    mreq_n |-> (rom_cs_n && ram_cs_n));

  assert_io_keeps_mode_R7: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && mreq_n) |=> $stable(run_mode));

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> !run_mode);

  assert_warm_on_entry_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run_mode) |-> warm_boot);

endmodule

bind boot_overlay_cs boot_overlay_cs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/boot_overlay_cs_tb.sv
module boot_overlay_cs_tb;
  logic clk = 1'b0;
  logic por_n, rst_n, mreq_n, iorq_n, rd_n, wr_n;
  logic [15:0] addr;
  logic [7:0]  io_data;
  logic rom_cs_n, ram_cs_n, run_mode, warm_boot, hard_reset_req;

  int checks = 0;
  int fails  = 0;
  bit m_ovl, m_warm, m_pend, m_hard, m_rstq;

  always #5 clk = ~clk;

  boot_overlay_cs u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .io_data(io_data),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .run_mode(run_mode),
    .warm_boot(warm_boot), .hard_reset_req(hard_reset_req));

  function automatic bit exp_rom(bit mq, bit wr, bit ovl);
    return !(!mq && !ovl && wr);
  endfunction

  function automatic bit exp_ram(bit mq, bit wr, bit ovl);
    return !(!mq && (ovl || !wr));
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic model_por();
    m_ovl = 0; m_warm = 0; m_pend = 1; m_hard = 0; m_rstq = 0;
  endtask

  task automatic model_next();
    bit hi, go, ent, clr;
    hi  = !mreq_n && !rd_n && addr[15];
    go  = rst_n && hi && !m_ovl;
    ent = !rst_n && m_rstq;
    clr = !iorq_n && !wr_n && addr[7:0] == 8'hF0 && io_data == 8'hA5;
    if (clr) m_warm = 0; else if (go) m_warm = 1;
    if (ent) begin m_hard = m_pend; m_pend = 1; end
    else if (go) m_pend = 0;
    if (!rst_n) m_ovl = 0; else if (hi) m_ovl = 1;
    m_rstq = rst_n;
  endtask

  task automatic step(input logic p, r, mq, iq, rd, wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    por_n = p; rst_n = r; mreq_n = mq; iorq_n = iq; rd_n = rd; wr_n = wr;
    addr = a; io_data = d;
    if (!p) model_por();
    #1;
    chk("R2 R3 R5 R7 rom_cs_n", rom_cs_n, exp_rom(mq, wr, m_ovl));
    chk("R3 R5 R6 R7 ram_cs_n", ram_cs_n, exp_ram(mq, wr, m_ovl));
    chk("R1 R4 R7 R8 run_mode", run_mode, m_ovl);
    chk("R1 R9 R10 warm_boot", warm_boot, m_warm);
    chk("R1 R11 hard_reset_req", hard_reset_req, m_hard);
    if (p) model_next();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_por();
    // R1: power-on state
    step(0, 0, 1, 1, 1, 1, 16'h0000, 8'h00);
    chk("R1 reset state run", run_mode, 1'b0);
    step(1, 1, 1, 1, 1, 1, 16'h0000, 8'h00);
    // R2: boot read at low address from ROM
    step(1, 1, 0, 1, 0, 1, 16'h0010, 8'h00);
    chk("R2 boot read rom", rom_cs_n, 1'b0);
    // R3: write under ROM range goes to RAM
    step(1, 1, 0, 1, 1, 0, 16'h1234, 8'h00);
    chk("R3 boot write ram", ram_cs_n, 1'b0);
    // R4: read at 8000h still from ROM in that cycle
    step(1, 1, 0, 1, 0, 1, 16'h8000, 8'h00);
    chk("R4 exit cycle rom", rom_cs_n, 1'b0);
    step(1, 1, 1, 1, 1, 1, 16'h0000, 8'h00);
    chk("R4 run after exit", run_mode, 1'b1);
    chk("R9 warm after exit", warm_boot, 1'b1);
    // R5: low read now from RAM
    step(1, 1, 0, 1, 0, 1, 16'h0000, 8'h00);
    chk("R5 run read ram", ram_cs_n, 1'b0);
    chk("R5 run read no rom", rom_cs_n, 1'b1);
    // R7: I/O read at high address selects nothing
    step(1, 1, 1, 0, 0, 1, 16'h8000, 8'h00);
    chk("R7 io no ram", ram_cs_n, 1'b1);
    // R8/R11: reset after a completed boot
    step(1, 0, 1, 1, 1, 1, 16'h0000, 8'h00);
    step(1, 1, 1, 1, 1, 1, 16'h0000, 8'h00);
    chk("R8 reset clears run", run_mode, 1'b0);
    chk("R9 warm kept over reset", warm_boot, 1'b1);
    chk("R11 no hard after clean boot", hard_reset_req, 1'b0);
    // R11: second reset with no exit
    step(1, 0, 1, 1, 1, 1, 16'h0000, 8'h00);
    step(1, 1, 1, 1, 1, 1, 16'h0000, 8'h00);
    chk("R11 double reset hard", hard_reset_req, 1'b1);
    // R10: wrong key, I/O read, then correct key
    step(1, 1, 1, 0, 1, 0, 16'h12F0, 8'h5A);
    step(1, 1, 1, 0, 0, 1, 16'h00F0, 8'hA5);
    step(1, 1, 1, 1, 1, 1, 16'h0000, 8'h00);
    chk("R10 wrong key or read keeps warm", warm_boot, 1'b1);
    step(1, 1, 1, 0, 1, 0, 16'h77F0, 8'hA5);
    step(1, 1, 1, 1, 1, 1, 16'h0000, 8'h00);
    chk("R10 keyed write clears warm", warm_boot, 1'b0);

    for (int i = 0; i < 20000; i++) begin
      int kind;
      logic p, r, mq, iq, rd, wr;
      logic [15:0] a;
      logic [7:0] d;
      kind = $urandom_range(0, 5);
      p = ($urandom_range(0, 999) != 0);
      r = ($urandom_range(0, 59) != 0);
      a = 16'($urandom());
      d = 8'($urandom());
      mq = 1; iq = 1; rd = 1; wr = 1;
      case (kind)
        1: begin mq = 0; rd = 0; end
        2: begin mq = 0; wr = 0; end
        3: begin iq = 0; rd = 0; end
        4: begin
          iq = 0; wr = 0;
          if ($urandom_range(0, 1) == 1) a[7:0] = 8'hF0;
          if ($urandom_range(0, 1) == 1) d = 8'hA5;
        end
        5: mq = 0;
        default: ;
      endcase
      step(p, r, mq, iq, rd, wr, a, d);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule